// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits behind the bus interface of a NOR-style flash device and turns host write cycles into device modes. It watches each write (word address plus data byte), walks the unlock handshake, and selects among three read modes: plain array data, the identifier codes, or the erase engine's status word while that engine runs. When a complete six-write chip erase sequence arrives it sends a single-cycle start pulse to an external erase engine. The array storage, the erase and program algorithms and the engine are outside the block. Array contents and engine status arrive as inputs, and the block only steers them onto the read data output.

The identifier codes are reached with a command, with no special voltage on an address line. The reset byte F0h works from any state, at any address. While the engine is busy it is the only write the decoder acts on, and it then also tells the engine to abandon a failed or running operation.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in array read mode: `rd_data` equals `array_rdata`, and `erase_start` and `erase_abort` are low.
- R2: While the engine is idle, a write of F0h at any address returns the decoder to array read mode from any state. Reads then return `array_rdata` until another command changes the mode.
- R3: The writes AAh at 555h, 55h at 2AAh and 90h at 555h, in that order, put the decoder in identifier mode.
- R4: In identifier mode `rd_addr`=0 returns 00C2h. `rd_addr`=1 returns 22C4h when `TOP_BOOT`=1 and 2249h when `TOP_BOOT`=0. `rd_addr`=2 or 3 returns 0000h.
- R5: Identifier mode persists until F0h is written, and any other write is ignored while in it.
- R6: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raise `erase_start` for exactly the one cycle after the clock edge that captures the sixth write. The decoder is back in array read mode afterwards.
- R7: Any write that does not match the next expected step of a sequence returns the decoder to array read mode without a start pulse. A matching step that follows it starts the sequence over from its first write.
- R8: While `eng_busy` is high, `rd_data` equals `eng_status` and writes other than F0h leave the mode unchanged.
- R9: A write of F0h while `eng_busy` is high raises `erase_abort` for exactly one cycle after the capturing edge and returns the decoder to array read mode.
- R10: `erase_start` and `erase_abort` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write cycle strobe, one cycle per write |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | 8 | Command byte of the write |
| rd_addr | input | 2 | Low two address bits of the current read |
| array_rdata | input | 16 | Data from the memory array |
| eng_busy | input | 1 | Erase engine is running |
| eng_status | input | 16 | Status word from the erase engine |
| rd_data | output | 16 | Selected read data |
| erase_start | output | 1 | One-cycle pulse that starts a chip erase |
| erase_abort | output | 1 | One-cycle pulse that abandons the engine's operation |

## Verification
The assertions assume that `eng_busy` comes from an engine that only runs after it has been started or that failed and was not yet aborted. The decoder does not rely on that pairing, so the stimulus drives `eng_busy` freely. The assertions also assume each write strobe lasts one cycle with stable address and data. The bench drives every write as a single-cycle strobe with a gap after it. Random writes are biased toward the legal command steps so that full erase and identifier sequences occur, and they are mixed with stray bytes and F0h at random addresses.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW       = 11,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [1:0]    rd_addr,
  input  logic [15:0]   array_rdata,
  input  logic          eng_busy,
  input  logic [15:0]   eng_status,
  output logic [15:0]   rd_data,
  output logic          erase_start,
  output logic          erase_abort
);
  localparam logic [AW-1:0] ADDR_A = AW'(12'h555);
  localparam logic [AW-1:0] ADDR_B = AW'(12'h2AA);
  localparam logic [15:0]   MFR_CODE = 16'h00C2;
  localparam logic [15:0]   DEV_CODE = TOP_BOOT ? 16'h22C4 : 16'h2249;

  typedef enum logic [2:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_SETUP, ST_ER1, ST_ER2, ST_IDENT
  } state_t;

  state_t state, state_nx;
  logic   start_nx, abort_nx;

  wire at_a   = wr_addr == ADDR_A;
  wire at_b   = wr_addr == ADDR_B;
  wire is_rst = wr_data == 8'hF0;
  wire key1   = at_a && wr_data == 8'hAA;
  wire key2   = at_b && wr_data == 8'h55;

  always_comb begin
    state_nx = state;
    start_nx = 1'b0;
    abort_nx = 1'b0;
    if (wr_en) begin
      if (eng_busy) begin
        if (is_rst) begin
          state_nx = ST_READ;
          abort_nx = 1'b1;
        end
      end else if (is_rst) begin
        state_nx = ST_READ;
      end else begin
        case (state)
          ST_READ:  state_nx = key1 ? ST_UNL1 : ST_READ;
          ST_UNL1:  state_nx = key2 ? ST_UNL2 : ST_READ;
          ST_UNL2:
            if (at_a && wr_data == 8'h90)      state_nx = ST_IDENT;
            else if (at_a && wr_data == 8'h80) state_nx = ST_SETUP;
            else                               state_nx = ST_READ;
          ST_SETUP: state_nx = key1 ? ST_ER1 : ST_READ;
          ST_ER1:   state_nx = key2 ? ST_ER2 : ST_READ;
          ST_ER2: begin
            state_nx = ST_READ;
            start_nx = at_a && wr_data == 8'h10;
          end
          ST_IDENT: state_nx = ST_IDENT;
          default:  state_nx = ST_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_READ;
      erase_start <= 1'b0;
      erase_abort <= 1'b0;
    end else begin
      state       <= state_nx;
      erase_start <= start_nx;
      erase_abort <= abort_nx;
    end
  end

  logic [15:0] id_word;
  always_comb begin
    case (rd_addr)
      2'd0:    id_word = MFR_CODE;
      2'd1:    id_word = DEV_CODE;
      default: id_word = 16'h0000;
    endcase
  end

  assign rd_data = eng_busy            ? eng_status :
                   (state == ST_IDENT) ? id_word    : array_rdata;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          eng_busy,
  input logic [15:0]   eng_status,
  input logic [15:0]   rd_data,
  input logic          erase_start,
  input logic          erase_abort
);
  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  // R6
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> $past(wr_en && !eng_busy && wr_data == 8'h10 &&
                          wr_addr == AW'(12'h555)));

  // R9
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_abort |-> $past(wr_en && eng_busy && wr_data == 8'hF0));

  // R9
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_abort |=> !erase_abort);

  // R10
  start_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_start, erase_abort}));

  // R8
  busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> rd_data == eng_status);
endmodule

bind flash_cmd_decoder fcd_checker #(.AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .eng_busy(eng_busy), .eng_status(eng_status),
  .rd_data(rd_data), .erase_start(erase_start), .erase_abort(erase_abort)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [15:0]   array_rdata = 16'h1234;
  logic          eng_busy = 1'b0;
  logic [15:0]   eng_status = 16'h0080;
  logic [15:0]   rd_data;
  logic          erase_start, erase_abort;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .TOP_BOOT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .array_rdata(array_rdata),
    .eng_busy(eng_busy), .eng_status(eng_status), .rd_data(rd_data),
    .erase_start(erase_start), .erase_abort(erase_abort)
  );

  // reference model: identifier flag and count of matched erase steps
  bit m_id = 1'b0;
  int m_step = 0;
  bit e_start = 1'b0;
  bit e_abort = 1'b0;

  function automatic logic [AW-1:0] step_addr(int s);
    return (s == 1 || s == 4) ? AW'(12'h2AA) : AW'(12'h555);
  endfunction

  function automatic logic [7:0] step_data(int s);
    case (s)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      2:    return 8'h80;
      default: return 8'h10;
    endcase
  endfunction

  function automatic logic [15:0] exp_read(logic [1:0] a);
    if (eng_busy) return eng_status;
    if (!m_id) return array_rdata;
    if (a == 2'd0) return 16'h00C2;
    if (a == 2'd1) return 16'h22C4;
    return 16'h0000;
  endfunction

  task automatic model_write(logic [AW-1:0] a, logic [7:0] d);
    e_start = 1'b0;
    e_abort = 1'b0;
    if (eng_busy) begin
      if (d == 8'hF0) begin
        e_abort = 1'b1; m_id = 1'b0; m_step = 0;
      end
    end else if (d == 8'hF0) begin
      m_id = 1'b0; m_step = 0;
    end else if (!m_id) begin
      if (m_step == 2 && a == AW'(12'h555) && d == 8'h90) begin
        m_id = 1'b1; m_step = 0;
      end else if (a == step_addr(m_step) && d == step_data(m_step)) begin
        m_step++;
        if (m_step == 6) begin
          e_start = 1'b1; m_step = 0;
        end
      end else begin
        m_step = 0;
      end
    end
  endtask

  task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive one write cycle; on return the capturing edge has passed
  task automatic wr(logic [AW-1:0] a, logic [7:0] d, string req);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
    check1({req, " start"}, erase_start, e_start);
    check1({req, " abort"}, erase_abort, e_abort);
    @(negedge clk);
    check1({req, " start drop"}, erase_start, 1'b0);
    check1({req, " abort drop"}, erase_abort, 1'b0);
  endtask

  task automatic rd_check(logic [1:0] a, string req);
    rd_addr = a;
    #1;
    check16(req, rd_data, exp_read(a));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd_check(2'd0, "R1 reset read");
    check1("R1 reset start", erase_start, 1'b0);
    check1("R1 reset abort", erase_abort, 1'b0);

    // R3 R4: identifier entry and codes
    wr(11'h555, 8'hAA, "R3"); wr(11'h2AA, 8'h55, "R3"); wr(11'h555, 8'h90, "R3");
    rd_check(2'd0, "R4 manufacturer");
    rd_check(2'd1, "R4 device");
    rd_check(2'd2, "R4 unused");
    check16("R3 id mode", rd_data, 16'h0000);
    // R5: stray writes ignored in identifier mode
    wr(11'h123, 8'h80, "R5"); wr(11'h555, 8'hAA, "R5");
    rd_check(2'd0, "R5 still identifier");
    // R8: busy ignores non-reset writes, shows status
    eng_busy = 1'b1; eng_status = 16'h00A5;
    rd_check(2'd1, "R8 busy status");
    wr(11'h555, 8'h10, "R8");
    eng_busy = 1'b0;
    rd_check(2'd1, "R8 mode kept");
    // R2: reset byte at an odd address
    wr(11'h07F, 8'hF0, "R2");
    array_rdata = 16'hBEEF;
    rd_check(2'd0, "R2 array read");

    // R6: full erase
    for (int s = 0; s < 6; s++) wr(step_addr(s), step_data(s), "R6");
    rd_check(2'd0, "R6 back to read");
    // R7: break at step 4 then restart
    for (int s = 0; s < 3; s++) wr(step_addr(s), step_data(s), "R7");
    wr(11'h2AA, 8'hAA, "R7 mismatch");
    wr(step_addr(4), step_data(4), "R7");
    wr(step_addr(5), step_data(5), "R7 no start");
    rd_check(2'd0, "R7 read mode");
    // R9: abort while busy
    eng_busy = 1'b1;
    wr(11'h000, 8'hF0, "R9 abort");
    eng_busy = 1'b0;
    rd_check(2'd1, "R9 read mode");

    // random mix; R10 covered by start/abort checks on every write
    for (int i = 0; i < 1500; i++) begin
      int pick;
      logic [AW-1:0] a;
      logic [7:0] d;
      pick = int'($urandom % 10);
      if (pick < 6) begin
        int s;
        s = int'($urandom % 6);
        a = step_addr(s); d = step_data(s);
      end else if (pick == 6) begin
        a = 11'h555; d = 8'h90;
      end else if (pick == 7) begin
        a = AW'($urandom); d = 8'hF0;
      end else begin
        a = AW'($urandom); d = 8'($urandom);
      end
      eng_busy = ($urandom % 8) == 0;
      eng_status = 16'($urandom);
      array_rdata = 16'($urandom);
      wr(a, d, "R10 random");
      rd_check(2'($urandom), "R2 R4 R8 random read");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule